// File: doc/BRIEF.md
# Time-Multiplexed Vertical Link

This block moves a group of single-bit signals from one stacked die to the next when the section has fewer working vertical vias than signals. A transmit side and a receive side share a global clock and a synchronous reset. Both read the same good-via mask from the via test, so both derive the same slot schedule. Each transmit cycle is one slot. In each slot the transmit side places a different subset of the signals onto the vias that tested good. The receive side captures each signal in its own slot and holds it in a register until that slot comes round again.

The number of good vias G sets the frame length. A frame lasts ceil(S/G) cycles, where S is the number of signals. With many good vias a frame is short, and with a single good via every signal waits its turn. When no via is usable the link raises an error and forces its outputs to zero. The design models both dies in one top module. The via bundle between them is brought out as an output so that it can be observed.

Top module: `tdm_via_link`

## Requirements
- R1: Let G be the number of 1 bits in `good_mask` (bit j = 1 means via j works). With G ≥ 1 a frame lasts ceil(NUM_SIG/G) cycles. `frame_start` is high exactly in slot 0 of each frame, so consecutive `frame_done` pulses are ceil(NUM_SIG/G) cycles apart.
- R2: Number the good vias in rank order from mask bit 0 upward, ranks 0 to G-1. In slot t, the good via of rank k drives `sig_in[t*G+k]`, or drives 0 if that index is NUM_SIG or higher.
- R3: A via whose mask bit is 0 always drives 0 on `via_drive`.
- R4: `sig_out[i]` takes the value that `sig_in[i]` had during slot floor(i/G). The new value is visible from the cycle after that slot.
- R5: Between its own slots, `sig_out[i]` holds its value unchanged.
- R6: `frame_done` is a one-cycle pulse in the cycle after the last slot of a frame. In that cycle every `sig_out` bit reflects the frame just ended, and the next frame's slot 0 is under way.
- R7: With G = 0, `link_err` is 1, every via drives 0 and `frame_start` is 0. After the next clock edge `sig_out` is all zero and `frame_done` is 0.
- R8: While `rst_n` is 0 at a clock edge, both sides return to slot 0, `sig_out` clears to 0 and `frame_done` clears to 0.
- R9: If a mask change leaves the current slot at or beyond the new last slot, the next edge wraps the schedule to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global link clock shared by both dies |
| rst_n | input | 1 | Synchronous active-low reset |
| good_mask | input | NUM_VIA | Via test result, 1 = usable via |
| sig_in | input | NUM_SIG | Logical signals on the sending die |
| via_drive | output | NUM_VIA | Values on the vertical vias |
| sig_out | output | NUM_SIG | Registered signals on the receiving die |
| frame_start | output | 1 | High during slot 0 of a frame |
| frame_done | output | 1 | One-cycle pulse after a frame's last slot |
| link_err | output | 1 | No usable via in the section |

## Verification
The bench covers the last slot of a frame that is only partly filled. There, vias of high rank must stay at 0, and a wrong index limit would put stale or out-of-range data on them. It uses sparse masks whose good vias are not at the low bit positions, because a design that maps by physical position instead of rank would scramble the signals. It also checks the single-via case, where a bit captured outside its slot would show up as a mid-frame change on an already delivered bit. Finally it checks that a mask of zero clears the outputs, and that a shortened frame wraps rather than running past its new end.

// File: rtl/tdm_link_pkg.sv
// Shared helpers for the time-multiplexed vertical link.
// Assumes the signal count and good-via count are small positive integers.
package tdm_link_pkg;

    // Slots needed to carry n_sig signals over n_good vias; 0 when no via works.
    function automatic int frame_slots(input int n_sig, input int n_good);
        if (n_good <= 0) begin
            return 0;
        end
        return (n_sig + n_good - 1) / n_good;
    endfunction

endpackage

// File: rtl/tdm_via_map.sv
// Ranks the usable vias of a section.
// Counts the good vias and gives each good via its rank, meaning how many good
// vias sit at lower bit positions. Bad vias get rank 0, which callers ignore.
// Assumes the mask is stable for the duration of a frame in normal use.
module tdm_via_map #(
    parameter int NUM_VIA = 4,
    localparam int CNT_W  = $clog2(NUM_VIA + 1)
) (
    input  logic [NUM_VIA-1:0] good_mask,
    output logic [CNT_W-1:0]   good_cnt,
    output logic [CNT_W-1:0]   rank [NUM_VIA]
);

    // Running count over the mask gives both the total and each via's rank.
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int j = 0; j < NUM_VIA; j++) begin
            rank[j] = good_mask[j] ? run : '0;
            if (good_mask[j]) begin
                run = run + CNT_W'(1);
            end
        end
        good_cnt = run;
    end

endmodule

// File: rtl/tdm_slot_ctr.sv
// Slot sequencer for one die.
// Steps through the slots of a frame and wraps after slot ceil(S/G)-1. It also
// wraps when a mask change has shortened the frame below the current slot.
// Held at slot 0 while no via works. Assumes both dies see the same reset edge.
module tdm_slot_ctr
    import tdm_link_pkg::*;
#(
    parameter int NUM_SIG = 6,
    parameter int NUM_VIA = 4,
    localparam int CNT_W  = $clog2(NUM_VIA + 1),
    localparam int SLOT_W = $clog2(NUM_SIG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  good_cnt,
    output logic [SLOT_W-1:0] slot,
    output logic              active
);

    logic wrap;

    // The link runs only when at least one via works.
    assign active = (good_cnt != '0);

    // Last slot of the current frame, or beyond it after a mask change.
    always_comb begin
        wrap = active && (int'(slot) >= frame_slots(NUM_SIG, int'(good_cnt)) - 1);
    end

    // Slot register: reset or no link gives slot 0, wrap restarts, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || wrap) begin
            slot <= '0;
        end else begin
            slot <= slot + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/tdm_tx_mux.sv
// Transmit multiplexer on the sending die.
// In slot t the good via of rank k carries signal t*G+k. Bad vias, indices
// beyond the signal count and an inactive link all drive 0. Purely combinational.
module tdm_tx_mux #(
    parameter int NUM_SIG = 6,
    parameter int NUM_VIA = 4,
    localparam int CNT_W  = $clog2(NUM_VIA + 1),
    localparam int SLOT_W = $clog2(NUM_SIG + 1)
) (
    input  logic [NUM_SIG-1:0] sig_in,
    input  logic [NUM_VIA-1:0] good_mask,
    input  logic [CNT_W-1:0]   good_cnt,
    input  logic [CNT_W-1:0]   rank [NUM_VIA],
    input  logic [SLOT_W-1:0]  slot,
    input  logic               active,
    output logic [NUM_VIA-1:0] via_drive
);

    // Select the signal each good via carries in the current slot.
    always_comb begin
        int base;
        int idx;
        base = int'(slot) * int'(good_cnt);
        for (int j = 0; j < NUM_VIA; j++) begin
            idx = base + int'(rank[j]);
            via_drive[j] = 1'b0;
            if (active && good_mask[j] && (idx < NUM_SIG)) begin
                via_drive[j] = sig_in[idx];
            end
        end
    end

endmodule

// File: rtl/tdm_rx_demux.sv
// Receive demultiplexer on the other die.
// Each output bit has a hold register that loads only in the slot carrying
// that signal. frame_done pulses after the last slot. An inactive link clears
// all hold registers. Assumes the slot input runs in lockstep with the sender.
module tdm_rx_demux
    import tdm_link_pkg::*;
#(
    parameter int NUM_SIG = 6,
    parameter int NUM_VIA = 4,
    localparam int CNT_W  = $clog2(NUM_VIA + 1),
    localparam int SLOT_W = $clog2(NUM_SIG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VIA-1:0] via_in,
    input  logic [NUM_VIA-1:0] good_mask,
    input  logic [CNT_W-1:0]   good_cnt,
    input  logic [CNT_W-1:0]   rank [NUM_VIA],
    input  logic [SLOT_W-1:0]  slot,
    input  logic               active,
    output logic [NUM_SIG-1:0] sig_out,
    output logic               frame_done
);

    logic [NUM_SIG-1:0] cap_en;
    logic [NUM_SIG-1:0] cap_val;
    logic               last_slot;

    // Work out which signals arrive in this slot and on which via.
    always_comb begin
        int base;
        base    = int'(slot) * int'(good_cnt);
        cap_en  = '0;
        cap_val = '0;
        for (int i = 0; i < NUM_SIG; i++) begin
            for (int j = 0; j < NUM_VIA; j++) begin
                if (good_mask[j] && (base + int'(rank[j]) == i)) begin
                    cap_en[i]  = 1'b1;
                    cap_val[i] = via_in[j];
                end
            end
        end
    end

    // Final slot of the frame, matching the sender's wrap rule.
    always_comb begin
        last_slot = active && (int'(slot) >= frame_slots(NUM_SIG, int'(good_cnt)) - 1);
    end

    // Hold registers: load in own slot, clear on reset or dead link.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sig_out <= '0;
        end else begin
            for (int i = 0; i < NUM_SIG; i++) begin
                if (cap_en[i]) begin
                    sig_out[i] <= cap_val[i];
                end
            end
        end
    end

    // End-of-frame pulse follows the last slot by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
        end else begin
            frame_done <= last_slot;
        end
    end

endmodule

// File: rtl/tdm_via_link.sv
// Time-multiplexed vertical link, both dies.
// The sending die ranks its vias, sequences slots and multiplexes the signals.
// The receiving die repeats the ranking and sequencing from the same mask and
// clock and demultiplexes into hold registers. Assumes a shared clock, a shared
// synchronous active-low reset and the same good-via mask on both dies.
module tdm_via_link #(
    parameter int NUM_SIG = 6,
    parameter int NUM_VIA = 4,
    localparam int CNT_W  = $clog2(NUM_VIA + 1),
    localparam int SLOT_W = $clog2(NUM_SIG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VIA-1:0] good_mask,
    input  logic [NUM_SIG-1:0] sig_in,
    output logic [NUM_VIA-1:0] via_drive,
    output logic [NUM_SIG-1:0] sig_out,
    output logic               frame_start,
    output logic               frame_done,
    output logic               link_err
);

    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  tx_rank [NUM_VIA];
    logic [SLOT_W-1:0] tx_slot;
    logic              tx_active;
    logic [CNT_W-1:0]  rx_cnt;
    logic [CNT_W-1:0]  rx_rank [NUM_VIA];
    logic [SLOT_W-1:0] rx_slot;
    logic              rx_active;

    // Sending die: ranking, slot sequencing, multiplexer.
    tdm_via_map #(.NUM_VIA(NUM_VIA)) u_tx_map (
        .good_mask (good_mask),
        .good_cnt  (tx_cnt),
        .rank      (tx_rank)
    );

    tdm_slot_ctr #(.NUM_SIG(NUM_SIG), .NUM_VIA(NUM_VIA)) u_tx_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .good_cnt (tx_cnt),
        .slot     (tx_slot),
        .active   (tx_active)
    );

    tdm_tx_mux #(.NUM_SIG(NUM_SIG), .NUM_VIA(NUM_VIA)) u_tx_mux (
        .sig_in    (sig_in),
        .good_mask (good_mask),
        .good_cnt  (tx_cnt),
        .rank      (tx_rank),
        .slot      (tx_slot),
        .active    (tx_active),
        .via_drive (via_drive)
    );

    // Receiving die: its own ranking and sequencing, then the demultiplexer.
    tdm_via_map #(.NUM_VIA(NUM_VIA)) u_rx_map (
        .good_mask (good_mask),
        .good_cnt  (rx_cnt),
        .rank      (rx_rank)
    );

    tdm_slot_ctr #(.NUM_SIG(NUM_SIG), .NUM_VIA(NUM_VIA)) u_rx_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .good_cnt (rx_cnt),
        .slot     (rx_slot),
        .active   (rx_active)
    );

    tdm_rx_demux #(.NUM_SIG(NUM_SIG), .NUM_VIA(NUM_VIA)) u_rx_demux (
        .clk        (clk),
        .rst_n      (rst_n),
        .via_in     (via_drive),
        .good_mask  (good_mask),
        .good_cnt   (rx_cnt),
        .rank       (rx_rank),
        .slot       (rx_slot),
        .active     (rx_active),
        .sig_out    (sig_out),
        .frame_done (frame_done)
    );

    // Frame marker and error flag come from the sending die.
    assign frame_start = tx_active && (tx_slot == '0);
    assign link_err    = !tx_active;

endmodule

// File: rtl/tdm_via_link_chk.sv
// Property checker for the time-multiplexed link, bound to the top module.
// Observes ports only.
module tdm_via_link_chk #(
    parameter int NUM_SIG = 6,
    parameter int NUM_VIA = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_VIA-1:0] good_mask,
    input logic [NUM_VIA-1:0] via_drive,
    input logic [NUM_SIG-1:0] sig_out,
    input logic               frame_start,
    input logic               frame_done,
    input logic               link_err
);

    AST_BAD_VIA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (via_drive & ~good_mask) == '0);                                   // R3

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> (via_drive == '0 && !frame_start));                   // R7

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> (sig_out == '0 && !frame_done));                      // R7

    AST_DONE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_start || link_err));                         // R6

    AST_HOLD_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !link_err) |=> $stable(sig_out[0]));              // R5

endmodule

bind tdm_via_link tdm_via_link_chk #(.NUM_SIG(NUM_SIG), .NUM_VIA(NUM_VIA)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .good_mask   (good_mask),
    .via_drive   (via_drive),
    .sig_out     (sig_out),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .link_err    (link_err)
);

// File: tb/tdm_via_link_test.sv
`timescale 1ns/100ps
module tdm_via_link_test;

    localparam int S = 6;
    localparam int V = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [V-1:0] good_mask = '1;
    logic [S-1:0] sig_in = '0;
    logic [V-1:0] via_drive;
    logic [S-1:0] sig_out;
    logic         frame_start;
    logic         frame_done;
    logic         link_err;

    int checks = 0;
    int errors = 0;
    logic [S-1:0] exp_q [$];
    logic mon_en = 1'b0;
    int cyc = 0;
    int last_done = -1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tdm_via_link #(.NUM_SIG(S), .NUM_VIA(V)) uut (
        .clk(clk), .rst_n(rst_n), .good_mask(good_mask), .sig_in(sig_in),
        .via_drive(via_drive), .sig_out(sig_out), .frame_start(frame_start),
        .frame_done(frame_done), .link_err(link_err)
    );

    function automatic int popc(input logic [V-1:0] m);
        int n = 0;
        for (int j = 0; j < V; j++) n += int'(m[j]);
        return n;
    endfunction

    function automatic int flen(input logic [V-1:0] m);
        int g = popc(m);
        return (g == 0) ? 0 : (S + g - 1) / g;
    endfunction

    // Expected via values for slot t (R2, R3).
    function automatic logic [V-1:0] exp_via(input logic [V-1:0] m, input logic [S-1:0] p, input int t);
        logic [V-1:0] v = '0;
        int g = popc(m);
        int r = 0;
        for (int j = 0; j < V; j++) begin
            if (m[j]) begin
                if (t * g + r < S) v[j] = p[t * g + r];
                r++;
            end
        end
        return v;
    endfunction

    // Expected frame result: slot-0 signals from a, the rest from b (R4).
    function automatic logic [S-1:0] exp_frame(input logic [V-1:0] m, input logic [S-1:0] a, input logic [S-1:0] b);
        logic [S-1:0] e;
        int g = popc(m);
        for (int i = 0; i < S; i++) e[i] = (i < g) ? a[i] : b[i];
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait at a falling edge until slot 0 of a frame.
    task automatic align();
        @(negedge clk);
        while (!frame_start) @(negedge clk);
    endtask

    // Driver: one frame, pattern a in slot 0 and b afterwards; pushes expected result.
    task automatic send_frame(input logic [S-1:0] a, input logic [S-1:0] b);
        int n = flen(good_mask);
        for (int t = 0; t < n; t++) begin
            sig_in = (t == 0) ? a : b;
            #0.5;
            check("R2/R3 via_drive", 32'(via_drive), 32'(exp_via(good_mask, sig_in, t)));
            check("R1 frame_start", 32'(frame_start), 32'(t == 0));
            if (t == 0) begin
                exp_q.push_back(exp_frame(good_mask, a, b));
                mon_en = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;
    endtask

    // Monitor: pops expected frames on frame_done and checks the spacing (R1, R4, R6).
    always @(posedge clk) begin
        cyc++;
        #2;
        if (!mon_en) begin
            last_done = -1;
        end else if (frame_done) begin
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R6 unexpected frame_done actual=1 expected=0");
            end else begin
                logic [S-1:0] e;
                e = exp_q.pop_front();
                check("R4/R6 sig_out at frame_done", 32'(sig_out), 32'(e));
            end
            if (last_done >= 0) check("R1 frame period", 32'(cyc - last_done), 32'(flen(good_mask)));
            last_done = cyc;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 sig_out in reset", 32'(sig_out), 0);
        check("R8 frame_done in reset", 32'(frame_done), 0);
        check("R8 frame_start in reset", 32'(frame_start), 1);
        rst_n = 1'b1;

        // All vias good: G=4, two slots, partial last slot
        good_mask = 4'b1111;
        align();
        send_frame(6'b101101, 6'b101101);
        send_frame(6'b010010, 6'b111111);
        send_frame(6'b110011, 6'b001100);
        drain();

        // Sparse mask: G=2, three slots, rank order not position
        good_mask = 4'b0101;
        align();
        send_frame(6'b011010, 6'b100101);
        send_frame(6'b111111, 6'b000000);
        drain();

        // Upper three good: G=3
        good_mask = 4'b1110;
        align();
        send_frame(6'b000101, 6'b110010);
        send_frame(6'b111000, 6'b010101);
        drain();

        // Single good via: G=1, six slots
        good_mask = 4'b1000;
        align();
        send_frame(6'b100110, 6'b011001);
        send_frame(6'b111111, 6'b111111);
        drain();

        // R5: mid-frame, only bits 0..2 have been reloaded
        sig_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 hold mid-frame", 32'(sig_out), 32'(6'b111000));

        // R9: shorten the frame while at slot 4
        align();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 not slot 0 before change", 32'(frame_start), 0);
        good_mask = 4'b1111;
        @(posedge clk);
        @(negedge clk);
        check("R9 wrapped to slot 0", 32'(frame_start), 1);

        // R7: no usable via
        good_mask = 4'b1111;
        align();
        send_frame(6'b111111, 6'b111111);
        drain();
        sig_in = '1;
        good_mask = 4'b0000;
        #0.5;
        check("R7 link_err", 32'(link_err), 1);
        check("R7 via_drive zero", 32'(via_drive), 0);
        check("R7 frame_start low", 32'(frame_start), 0);
        @(posedge clk);
        @(negedge clk);
        check("R7 sig_out cleared", 32'(sig_out), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                seen += int'(frame_done);
            end
            check("R7 no frame_done", 32'(seen), 0);
        end

        // Recovery and R8 mid-frame reset with G=1
        good_mask = 4'b0010;
        align();
        send_frame(6'b010110, 6'b101001);
        drain();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 sig_out after reset", 32'(sig_out), 0);
        check("R8 slot 0 after reset", 32'(frame_start), 1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 slot advanced after release", 32'(frame_start), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule